// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Range Flags

This block multiplies two 32-bit binary floating-point words in the common single-precision layout: one sign bit in bit 31, an 8-bit biased exponent in bits 30:23 with bias 127, and a 23-bit fraction in bits 22:0. It returns a 32-bit product word and two flags, `ovf` and `unf`. These flags report an exponent that fell outside the normal range. The sign of the product is the exclusive-OR of the operand signs. The exponent is the sum of the biased exponents minus the bias, held in a 10-bit two's-complement intermediate. The two 24-bit significands, each with its hidden one, form a 48-bit product. That product is normalized with at most one right shift, and the fraction is truncated.

The block runs a small control sequence with four states. `ST_IDLE` waits for `start`. A high `start` latches both operands and moves to `ST_CALC`. `ST_CALC` registers the classified operands, the intermediate exponent and the significand product, then always moves to `ST_NORM`. `ST_NORM` normalizes, checks the range, writes the output registers and always moves to `ST_DONE`. `ST_DONE` raises `done` for one cycle and always returns to `ST_IDLE`. `busy` is high in every state except `ST_IDLE`. The product word and the flags hold their value until the next result is written.

Top module: `fpmul_unit`

## Requirements
- R1: The sign bit (31) of every result other than the quiet NaN equals the XOR of the two operand sign bits.
- R2: For two normal operands with an in-range result, bits 30:23 hold E1+E2-127 (plus the normalization step of R3), and bits 22:0 hold the 23 product bits just below the leading one, with lower bits dropped. Neither flag is set.
- R3: When bit 47 of the 48-bit significand product is set, the product is taken one place lower (fraction = bits 46:24) and the exponent is increased by one. Otherwise the fraction is bits 45:23.
- R4: If the final exponent exceeds 254, the result is infinity with the computed sign (exponent 8'hFF, fraction 0), `ovf`=1 and `unf`=0.
- R5: If the final exponent is below 1, the result is zero with the computed sign (bits 30:0 all zero), `unf`=1 and `ovf`=0. A negative intermediate exponent always ends here. An intermediate exponent of exactly 0 ends here when no normalization step applies.
- R6: An intermediate exponent of exactly 0 whose product has bit 47 set gives a normal result with exponent 1 and no flags.
- R7: An operand with exponent field 0 counts as zero. Multiplying it by a finite operand gives zero with the computed sign and no flags.
- R8: A NaN operand (exponent 8'hFF, fraction nonzero), or zero times infinity, gives the quiet NaN 32'h7FC00000 with no flags. Infinity times a nonzero finite operand or times infinity gives infinity with the computed sign and no flags.
- R9: A `start` sampled high in `ST_IDLE` gives `done` high for exactly one cycle, on the third rising edge after the sampling edge. `start` is ignored while `busy` is high.
- R10: After reset, `busy`, `done`, `ovf`, `unf` and `product` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a multiply; sampled only when idle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| busy | output | 1 | High from acceptance until the result cycle ends |
| done | output | 1 | One-cycle pulse marking a fresh result |
| product | output | 32 | Product word |
| ovf | output | 1 | Result exponent was too large; product is signed infinity |
| unf | output | 1 | Result exponent was too small; product is signed zero |

## Verification
The checker assumes that `start` stays low during reset. It also assumes that the operands offered together with an accepted `start` are the ones whose sign it latches, so it relies on the block sampling the operands only in the idle state. The stimulus drives `start` for one cycle and holds it low until `done`. One directed case deliberately raises `start` while busy, with different operands, to show that those operands are ignored. The random operands draw exponents over the full 0–255 field, so zero, infinity, NaN, overflow and underflow all occur next to ordinary products.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_NORM = 2'd1,
        CL_INF  = 2'd2,
        CL_NAN  = 2'd3
    } fclass_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_NORM = 2'd2,
        ST_DONE = 2'd3
    } fpm_state_e;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  sign,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       sig,
    output fclass_e               cls
);
    logic [FRAC_W-1:0] frac;

    always_comb begin
        sign = word[EXP_W+FRAC_W];
        expo = word[EXP_W+FRAC_W-1:FRAC_W];
        frac = word[FRAC_W-1:0];
        sig  = {(expo != '0), frac};
        if (expo == '0)
            cls = CL_ZERO;
        else if (expo == '1)
            cls = (frac == '0) ? CL_INF : CL_NAN;
        else
            cls = CL_NORM;
    end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
    parameter int SIG_W = 24,
    localparam int PW   = 2 * SIG_W
) (
    input  logic [SIG_W-1:0] sig_a,
    input  logic [SIG_W-1:0] sig_b,
    output logic [PW-1:0]    prod
);
    always_comb begin
        prod = PW'(sig_a) * PW'(sig_b);
    end
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IEXP_W = EXP_W + 2,
    localparam int PW    = 2 * (FRAC_W + 1),
    localparam int WW    = EXP_W + FRAC_W + 1
) (
    input  logic                     sign,
    input  fclass_e                  cls_a,
    input  fclass_e                  cls_b,
    input  logic signed [IEXP_W-1:0] iexp,
    input  logic [PW-1:0]            prod,
    output logic [WW-1:0]            word,
    output logic                     ovf,
    output logic                     unf
);
    localparam int EMAX = (1 << EXP_W) - 2;

    logic                     top;
    logic [FRAC_W-1:0]        frac;
    logic signed [IEXP_W-1:0] efin;
    int                       efin_i;
    logic                     any_nan, any_inf, any_zero;

    always_comb begin
        top    = prod[PW-1];
        frac   = top ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];
        efin   = iexp + (top ? IEXP_W'(1) : IEXP_W'(0));
        efin_i = int'(efin);

        any_nan  = (cls_a == CL_NAN) || (cls_b == CL_NAN) ||
                   ((cls_a == CL_ZERO) && (cls_b == CL_INF)) ||
                   ((cls_a == CL_INF) && (cls_b == CL_ZERO));
        any_inf  = (cls_a == CL_INF) || (cls_b == CL_INF);
        any_zero = (cls_a == CL_ZERO) || (cls_b == CL_ZERO);

        ovf  = 1'b0;
        unf  = 1'b0;
        if (any_nan) begin
            word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        end else if (any_inf) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (any_zero) begin
            word = {sign, {(WW-1){1'b0}}};
        end else if (efin_i > EMAX) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf  = 1'b1;
        end else if (efin_i < 1) begin
            word = {sign, {(WW-1){1'b0}}};
            unf  = 1'b1;
        end else begin
            word = {sign, efin[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/fpmul_unit.sv
module fpmul_unit
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WW     = EXP_W + FRAC_W + 1,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PW     = 2 * SIG_W,
    localparam int IEXP_W = EXP_W + 2,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] op_a,
    input  logic [WW-1:0] op_b,
    output logic          busy,
    output logic          done,
    output logic [WW-1:0] product,
    output logic          ovf,
    output logic          unf
);
    fpm_state_e state_q, state_d;

    logic [WW-1:0] opnd_q [2];

    logic             sgn_w  [2];
    logic [EXP_W-1:0] exp_w  [2];
    logic [SIG_W-1:0] sig_w  [2];
    fclass_e          cls_w  [2];

    logic [PW-1:0]            prod_w;
    logic signed [IEXP_W-1:0] iexp_w;

    logic [PW-1:0]            prod_q;
    logic signed [IEXP_W-1:0] iexp_q;
    logic                     sign_q;
    fclass_e                  cls_q [2];

    logic [WW-1:0] word_w;
    logic          ovf_w, unf_w;

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_opnd
            fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
                .word (opnd_q[gi]),
                .sign (sgn_w[gi]),
                .expo (exp_w[gi]),
                .sig  (sig_w[gi]),
                .cls  (cls_w[gi])
            );
        end
    endgenerate

    fpm_sigmul #(.SIG_W(SIG_W)) u_mul (
        .sig_a (sig_w[0]),
        .sig_b (sig_w[1]),
        .prod  (prod_w)
    );

    always_comb begin
        iexp_w = $signed(IEXP_W'(exp_w[0])) + $signed(IEXP_W'(exp_w[1]))
               - $signed(IEXP_W'(BIAS));
    end

    fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IEXP_W(IEXP_W)) u_pack (
        .sign  (sign_q),
        .cls_a (cls_q[0]),
        .cls_b (cls_q[1]),
        .iexp  (iexp_q),
        .prod  (prod_q),
        .word  (word_w),
        .ovf   (ovf_w),
        .unf   (unf_w)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;
            ST_CALC: state_d = ST_NORM;
            ST_NORM: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q[0] <= '0;
            opnd_q[1] <= '0;
            prod_q    <= '0;
            iexp_q    <= '0;
            sign_q    <= 1'b0;
            cls_q[0]  <= CL_ZERO;
            cls_q[1]  <= CL_ZERO;
            product   <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        opnd_q[0] <= op_a;
                        opnd_q[1] <= op_b;
                    end
                end
                ST_CALC: begin
                    prod_q   <= prod_w;
                    iexp_q   <= iexp_w;
                    sign_q   <= sgn_w[0] ^ sgn_w[1];
                    cls_q[0] <= cls_w[0];
                    cls_q[1] <= cls_w[1];
                end
                ST_NORM: begin
                    product <= word_w;
                    ovf     <= ovf_w;
                    unf     <= unf_w;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);
endmodule

// File: rtl/fpmul_checker.sv
module fpmul_checker #(
    parameter int WW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [WW-1:0] op_a,
    input logic [WW-1:0] op_b,
    input logic          busy,
    input logic          done,
    input logic [WW-1:0] product,
    input logic          ovf,
    input logic          unf
);
    localparam logic [WW-1:0] QNAN = {1'b0, 8'hFF, 1'b1, {(WW-10){1'b0}}};

    logic sign_exp;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               sign_exp <= 1'b0;
        else if (start && !busy)  sign_exp <= op_a[WW-1] ^ op_b[WW-1];
    end

    // R1
    sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && product != QNAN) |-> product[WW-1] == sign_exp);

    // R4
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (product[WW-2:0] == {8'hFF, {(WW-9){1'b0}}} && !unf));

    // R5
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unf) |-> (product[WW-2:0] == '0 && !ovf));

    // R8
    nan_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && product == QNAN) |-> (!ovf && !unf));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && !busy, 2) |-> ##1 done);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind fpmul_unit fpmul_checker #(.WW(WW)) u_fpmul_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product),
    .ovf     (ovf),
    .unf     (unf)
);

// File: tb/tb_fpmul_unit.sv
`timescale 1ns/1ps
module tb_fpmul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done, ovf, unf;
    logic [31:0] product;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fpmul_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product), .ovf(ovf), .unf(unf)
    );

    // expected {ovf, unf, word}
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic [7:0] ea, eb;
        logic [22:0] fa, fb;
        logic s, za, zb, ia, ib, na, nb;
        logic [47:0] m;
        logic [22:0] fr;
        int e;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        s  = a[31] ^ b[31];
        za = (ea == 8'h00); zb = (eb == 8'h00);
        ia = (ea == 8'hFF) && (fa == 0); ib = (eb == 8'hFF) && (fb == 0);
        na = (ea == 8'hFF) && (fa != 0); nb = (eb == 8'hFF) && (fb != 0);
        if (na || nb || (za && ib) || (ia && zb)) return {2'b00, 32'h7FC00000};
        if (ia || ib) return {2'b00, s, 8'hFF, 23'h0};
        if (za || zb) return {2'b00, s, 31'h0};
        m = {24'h0, 1'b1, fa} * {24'h0, 1'b1, fb};
        e = int'(ea) + int'(eb) - 127;
        if (m[47]) begin e = e + 1; fr = m[46:24]; end
        else       fr = m[45:23];
        if (e > 254) return {2'b10, s, 8'hFF, 23'h0};
        if (e < 1)   return {2'b01, s, 31'h0};
        return {2'b00, s, e[7:0], fr};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b, input logic [33:0] x);
        if (x[31:0] == 32'h7FC00000 || a[30:23] == 8'hFF || b[30:23] == 8'hFF) return "R8";
        if (a[30:23] == 8'h00 || b[30:23] == 8'h00) return "R7";
        if (x[33]) return "R4";
        if (x[32]) return "R5";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one multiply, return observed {ovf,unf,product} and latency in negedges
    task automatic run(input logic [31:0] a, input logic [31:0] b, output logic [33:0] got, output int lat);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        got = {ovf, unf, product};
    endtask

    task automatic run_chk(input logic [31:0] a, input logic [31:0] b, input string req);
        logic [33:0] got, exp;
        int lat;
        run(a, b, got, lat);
        exp = ref_mul(a, b);
        check(req.len() == 0 ? tag_of(a, b, exp) : req, got, exp);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [33:0] got;
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {busy, done, ovf, unf, product[29:0]}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {busy, done, ovf, unf, product[29:0]}, 34'h0);

        // R2 / R9: 2 x 3 = 6, latency and pulse width
        run(32'h40000000, 32'h40400000, got, lat);
        check("R2", got, {2'b00, 32'h40C00000});
        check("R9", 34'(lat), 34'd3);
        @(negedge clk);
        check("R9", {33'h0, done}, 34'h0);

        // R1: negative operand
        run_chk(32'hC0000000, 32'h40400000, "R1");
        run(32'hC0000000, 32'hC0400000, got, lat);
        check("R1", got, {2'b00, 32'h40C00000});

        // R3: leading one at bit 47 (1.5 x 1.5 = 2.25)
        run(32'h3FC00000, 32'h3FC00000, got, lat);
        check("R3", got, {2'b00, 32'h40100000});

        // R2: top exponent 254 stays normal
        run_chk(32'h7F000000, 32'h3F800000, "R2");
        // R4: overflow at 255 and far beyond
        run(32'h7F000000, 32'h40000000, got, lat);
        check("R4", got, {2'b10, 32'h7F800000});
        run(32'hFF000000, 32'h7F000000, got, lat);
        check("R4", got, {2'b10, 32'hFF800000});

        // R5: negative intermediate exponent
        run(32'h00800000, 32'h80800000, got, lat);
        check("R5", got, {2'b01, 32'h80000000});
        // R5: exactly zero, no normalization step
        run(32'h1F800000, 32'h20000000, got, lat);
        check("R5", got, {2'b01, 32'h00000000});
        // R6: exactly zero recovered by normalization
        run(32'h1FFFFFFF, 32'h20400000, got, lat);
        check("R6", {got[33:32], got[30:23]}, {2'b00, 8'h01});
        run_chk(32'h1FFFFFFF, 32'h20400000, "R6");

        // R7: zero operands
        run(32'h80000000, 32'h40400000, got, lat);
        check("R7", got, {2'b00, 32'h80000000});
        run(32'h00400000, 32'h3F800000, got, lat);
        check("R7", got, {2'b00, 32'h00000000});

        // R8: specials
        run(32'h00000000, 32'h7F800000, got, lat);
        check("R8", got, {2'b00, 32'h7FC00000});
        run(32'h7F800001, 32'h3F800000, got, lat);
        check("R8", got, {2'b00, 32'h7FC00000});
        run(32'hFF800000, 32'h40000000, got, lat);
        check("R8", got, {2'b00, 32'hFF800000});

        // R9: start while busy is ignored
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40400000; start = 1'b1;
        @(negedge clk);
        op_a = 32'h7F000000; op_b = 32'h7F000000;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R9", {ovf, unf, product}, {2'b00, 32'h40C00000});
        check("R9", {33'h0, done}, 34'h1);
        @(negedge clk);
        check("R9", {33'h0, done}, 34'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 3 == 0) begin
                ra[30:23] = 8'(63 + $urandom_range(0, 128));
                rb[30:23] = 8'(63 + $urandom_range(0, 128));
            end
            run_chk(ra, rb, "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule